// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block tracks reservations for load-linked / store-conditional pairs. It keeps one reservation per hardware thread. A load-linked request records the 16-byte aligned granule that holds its physical address and marks that thread's reservation as live. A later store-conditional from the same thread is let through to memory only if the reservation is still live and the store falls in the same granule. The block answers every accepted request with a registered decision and a result code. That code is what the core writes back as the store-conditional outcome.

Uncacheable store-conditionals are not checked at all. They always go to memory and report a distinct code. To help find livelock, the block counts how many store-conditionals in a row have failed on each thread. It pulses a warning on every tenth failure and raises a sticky per-thread deadlock flag when the count reaches 5000.

Top module: `resv_monitor`

## Requirements
- R1: A request with `req_op`=0 (load-linked) stores `req_addr` with bits [3:0] forced to zero as the reservation of thread `req_tid` and makes that reservation live. Its response has `rsp_forward`=1 and `rsp_code`=0.
- R2: Each thread has its own reservation and its own failure count. A request changes only the state of the thread named by `req_tid`.
- R3: A cacheable store-conditional (`req_op`=1, `req_uncached`=0) passes when its thread's reservation is live and `req_addr` with bits [3:0] cleared equals the stored granule. A pass gives `rsp_forward`=1 and `rsp_code`=1, kills the reservation, and resets that thread's failure count to 0.
- R4: A cacheable store-conditional that does not pass gives `rsp_forward`=0 and `rsp_code`=0, and kills its thread's reservation.
- R5: A store-conditional with `req_uncached`=1 gives `rsp_forward`=1 and `rsp_code`=2 whatever the reservation holds. It leaves the reservation and the failure count unchanged.
- R6: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low at every other time. The response fields belong to that request.
- R7: Each failed cacheable store-conditional adds one to its thread's failure count. `rsp_warn` is high with that response when the new count is a nonzero multiple of 10.
- R8: When a thread's failure count reaches exactly 5000, bit `req_tid` of `fatal` becomes 1 with that response. It stays 1 until reset.
- R9: The failure count stops at 8191 and does not wrap. Failures at the stopped value raise no warning.
- R10: Synchronous active-high reset kills all reservations, zeroes all failure counts, and clears `rsp_valid`, `rsp_warn` and `fatal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = load-linked, 1 = store-conditional |
| req_tid | input | 2 | Issuing thread |
| req_addr | input | 32 | Physical address |
| req_uncached | input | 1 | Uncacheable attribute of the access |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_forward | output | 1 | 1 = access may go to memory |
| rsp_code | output | 2 | 0 none/fail, 1 success, 2 uncacheable bypass |
| rsp_warn | output | 1 | Failure count just reached a multiple of 10 |
| fatal | output | 4 | Sticky per-thread deadlock flag |

## Verification
Two things can happen in the same response cycle: a failed store-conditional's response, and the livelock tracker's warning and deadlock outputs that the same failure triggers. At the 5000th failure the warning and the deadlock flag both rise with the failure response. The bench forces this by sending thousands of store-conditionals back to back on a thread whose reservation is dead. Its model predicts the code, the forward bit, the warning and the whole deadlock vector for every response, and compares all four in the response cycle. It keeps pushing past the count limit and then passes once, to show the limit holds and that a pass resets the count.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic {
        OP_LINK = 1'b0,
        OP_COND = 1'b1
    } op_e;

    typedef enum logic [1:0] {
        RC_NONE   = 2'd0,
        RC_PASS   = 2'd1,
        RC_BYPASS = 2'd2
    } rc_e;

    typedef struct packed {
        logic fwd;
        rc_e  code;
    } decision_t;

endpackage

// File: rtl/resv_slot.sv
module resv_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic              kill_i,
    input  logic [ADDR_W-1:0] gran_i,
    output logic              live_o,
    output logic [ADDR_W-1:0] gran_o
);

    logic              live_q;
    logic [ADDR_W-1:0] gran_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            gran_q <= '0;
        end else if (set_i) begin
            live_q <= 1'b1;
            gran_q <= gran_i;
        end else if (kill_i) begin
            live_q <= 1'b0;
        end
    end

    assign live_o = live_q;
    assign gran_o = gran_q;

    AST_LINK_ARMS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> (live_q && gran_q == $past(gran_i))); // R1

    AST_KILL_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (kill_i && !set_i) |=> !live_q); // R4

endmodule

// File: rtl/fail_counter.sv
module fail_counter #(
    parameter int CNT_W       = 13,
    parameter int WARN_PERIOD = 10,
    parameter int FATAL_LIMIT = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_i,
    input  logic pass_i,
    output logic warn_o,
    output logic fatal_o
);

    localparam int PH_W = (WARN_PERIOD > 1) ? $clog2(WARN_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] FATAL_PRE = CNT_W'(FATAL_LIMIT - 1);
    localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(WARN_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PH_W-1:0]  phase_q;
    logic             fatal_q;
    logic             bump;
    logic             hit_fatal;

    always_comb begin
        bump      = fail_i && (cnt_q != CNT_MAX);
        warn_o    = bump && (phase_q == PH_LAST);
        hit_fatal = bump && (cnt_q == FATAL_PRE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= '0;
            fatal_q <= 1'b0;
        end else begin
            if (pass_i) begin
                cnt_q   <= '0;
                phase_q <= '0;
            end else if (bump) begin
                cnt_q   <= cnt_q + 1'b1;
                phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
            end
            if (hit_fatal) begin
                fatal_q <= 1'b1;
            end
        end
    end

    assign fatal_o = fatal_q;

    AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (rst)
        fatal_q |=> fatal_q); // R8

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && fail_i) |=> (cnt_q == CNT_MAX)); // R9

    AST_PASS_ZEROES: assert property (@(posedge clk) disable iff (rst)
        pass_i |=> (cnt_q == '0)); // R3

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (fail_i && !pass_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R7

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int ADDR_W      = 32,
    parameter int GRAN_BITS   = 4,
    parameter int CNT_W       = 13,
    parameter int WARN_PERIOD = 10,
    parameter int FATAL_LIMIT = 5000
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  req_valid,
    input  logic                                  req_op,
    input  logic [$clog2(NUM_THREADS)-1:0]        req_tid,
    input  logic [ADDR_W-1:0]                     req_addr,
    input  logic                                  req_uncached,
    output logic                                  rsp_valid,
    output logic                                  rsp_forward,
    output logic [1:0]                            rsp_code,
    output logic                                  rsp_warn,
    output logic [NUM_THREADS-1:0]                fatal
);

    localparam int TID_W = $clog2(NUM_THREADS);
    localparam logic [ADDR_W-1:0] GRAN_MASK =
        {{(ADDR_W-GRAN_BITS){1'b1}}, {GRAN_BITS{1'b0}}};

    logic [ADDR_W-1:0]      req_gran;
    logic [NUM_THREADS-1:0] live_v;
    logic [ADDR_W-1:0]      gran_v [NUM_THREADS];
    logic [NUM_THREADS-1:0] set_v, kill_v, fail_v, pass_v, warn_v;

    logic      is_link, is_cond_c, is_cond_u;
    logic      sel_live;
    logic [ADDR_W-1:0] sel_gran;
    logic      cond_ok;
    decision_t dec;

    logic      valid_q;
    decision_t dec_q;
    logic      warn_q;

    always_comb begin
        req_gran  = req_addr & GRAN_MASK;
        is_link   = req_valid && (op_e'(req_op) == OP_LINK);
        is_cond_c = req_valid && (op_e'(req_op) == OP_COND) && !req_uncached;
        is_cond_u = req_valid && (op_e'(req_op) == OP_COND) && req_uncached;
        sel_live  = live_v[req_tid];
        sel_gran  = gran_v[req_tid];
        cond_ok   = sel_live && (sel_gran == req_gran);
    end

    always_comb begin
        dec.fwd  = 1'b1;
        dec.code = RC_NONE;
        if (is_cond_u) begin
            dec.code = RC_BYPASS;
        end else if (is_cond_c) begin
            if (cond_ok) begin
                dec.code = RC_PASS;
            end else begin
                dec.fwd  = 1'b0;
            end
        end
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        logic mine;
        assign mine      = (req_tid == TID_W'(t));
        assign set_v[t]  = is_link && mine;
        assign kill_v[t] = is_cond_c && mine;
        assign fail_v[t] = is_cond_c && mine && !cond_ok;
        assign pass_v[t] = is_cond_c && mine && cond_ok;

        resv_slot #(
            .ADDR_W (ADDR_W)
        ) u_slot (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[t]),
            .kill_i (kill_v[t]),
            .gran_i (req_gran),
            .live_o (live_v[t]),
            .gran_o (gran_v[t])
        );

        fail_counter #(
            .CNT_W       (CNT_W),
            .WARN_PERIOD (WARN_PERIOD),
            .FATAL_LIMIT (FATAL_LIMIT)
        ) u_fail (
            .clk     (clk),
            .rst     (rst),
            .fail_i  (fail_v[t]),
            .pass_i  (pass_v[t]),
            .warn_o  (warn_v[t]),
            .fatal_o (fatal[t])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            dec_q   <= '0;
            warn_q  <= 1'b0;
        end else begin
            valid_q <= req_valid;
            dec_q   <= dec;
            warn_q  <= |warn_v;
        end
    end

    assign rsp_valid   = valid_q;
    assign rsp_forward = dec_q.fwd;
    assign rsp_code    = dec_q.code;
    assign rsp_warn    = warn_q;

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R6

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R6

    AST_BYPASS_CODE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op && req_uncached) |=> (rsp_forward && rsp_code == 2'd2)); // R5

    AST_BLOCKED_IS_FAIL: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_forward) |-> (rsp_code == 2'd0)); // R4

    AST_WARN_WITH_FAIL: assert property (@(posedge clk) disable iff (rst)
        rsp_warn |-> (rsp_valid && !rsp_forward)); // R7

    AST_ONE_THREAD: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_v | kill_v)); // R2

endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 4;
    localparam int AW = 32;
    localparam int CMAX = 8191;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_op = 1'b0;
    logic [1:0]    req_tid = '0;
    logic [AW-1:0] req_addr = '0;
    logic          req_uncached = 1'b0;
    logic          rsp_valid, rsp_forward, rsp_warn;
    logic [1:0]    rsp_code;
    logic [NT-1:0] fatal;

    always #(CLK_PERIOD/2) clk = ~clk;

    resv_monitor u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_tid      (req_tid),
        .req_addr     (req_addr),
        .req_uncached (req_uncached),
        .rsp_valid    (rsp_valid),
        .rsp_forward  (rsp_forward),
        .rsp_code     (rsp_code),
        .rsp_warn     (rsp_warn),
        .fatal        (fatal)
    );

    typedef struct {
        logic [1:0]    code;
        logic          fwd;
        logic          warn;
        logic [NT-1:0] fat;
        string         tag;
    } exp_t;

    exp_t q[$];
    exp_t cur;
    int   n_cmp = 0;
    int   n_bad = 0;

    bit            m_live [NT];
    logic [AW-1:0] m_gran [NT];
    int            m_cnt  [NT];
    bit            m_fat  [NT];

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_live[t] = 0; m_gran[t] = '0; m_cnt[t] = 0; m_fat[t] = 0;
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // driver: one request per negedge, expected result pushed to the scoreboard
    task automatic issue(bit op, int tid, logic [AW-1:0] a, bit unc, string tag);
        exp_t e;
        logic [AW-1:0] g;
        g = a & 32'hFFFF_FFF0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_tid = 2'(tid);
        req_addr = a; req_uncached = unc;
        e.code = 2'd0; e.fwd = 1'b1; e.warn = 1'b0; e.tag = tag;
        if (!op) begin
            m_live[tid] = 1; m_gran[tid] = g;
        end else if (unc) begin
            e.code = 2'd2;
        end else if (m_live[tid] && m_gran[tid] == g) begin
            e.code = 2'd1; m_live[tid] = 0; m_cnt[tid] = 0;
        end else begin
            e.fwd = 1'b0; m_live[tid] = 0;
            if (m_cnt[tid] < CMAX) begin
                m_cnt[tid]++;
                e.warn = (m_cnt[tid] % 10 == 0);
                if (m_cnt[tid] == 5000) m_fat[tid] = 1;
            end
        end
        for (int t = 0; t < NT; t++) e.fat[t] = m_fat[t];
        q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // monitor: compare each response one step after the edge that makes it
    always begin
        @(posedge clk);
        #1;
        if (!rst) begin
            if (q.size() > 0) begin
                cur = q.pop_front();
                chk(cur.tag, "rsp_valid R6", 32'(rsp_valid), 32'd1);
                chk(cur.tag, "rsp_code", 32'(rsp_code), 32'(cur.code));
                chk(cur.tag, "rsp_forward", 32'(rsp_forward), 32'(cur.fwd));
                chk(cur.tag, "rsp_warn R7", 32'(rsp_warn), 32'(cur.warn));
                chk(cur.tag, "fatal R8", 32'(fatal), 32'(cur.fat));
            end else if (rsp_valid) begin
                chk("R6", "unexpected rsp_valid", 32'(rsp_valid), 32'd0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R10: outputs after reset
        chk("R10", "rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10", "rsp_warn", 32'(rsp_warn), 32'd0);
        chk("R10", "fatal", 32'(fatal), 32'd0);
        rst = 1'b0;

        issue(1, 0, 32'h0000_1000, 0, "R10 no reservation after reset");
        // R1 / R3: same granule, different byte
        issue(0, 0, 32'h0000_1004, 0, "R1 link");
        issue(1, 0, 32'h0000_100C, 0, "R3 pass same granule");
        issue(1, 0, 32'h0000_100C, 0, "R3 reservation killed by pass");
        idle(2);
        // R4: next granule misses
        issue(0, 1, 32'h0000_2000, 0, "R1 link t1");
        issue(1, 1, 32'h0000_2010, 0, "R4 granule mismatch");
        issue(1, 1, 32'h0000_2000, 0, "R4 reservation killed by fail");
        // R2: thread isolation
        issue(0, 2, 32'h0000_3000, 0, "R2 link t2");
        issue(0, 3, 32'h0000_4000, 0, "R2 link t3");
        issue(1, 2, 32'h0000_4000, 0, "R2 t2 uses t3 address");
        issue(1, 3, 32'h0000_4008, 0, "R2 t3 intact");
        idle(1);
        // R5: uncacheable bypass leaves reservation alone
        issue(0, 0, 32'h0000_5000, 0, "R5 link");
        issue(1, 0, 32'h0000_9990, 1, "R5 bypass");
        issue(1, 0, 32'h0000_5000, 0, "R5 reservation survives bypass");
        // R7 / R8 / R9: long failure run on thread 1
        for (int i = 0; i < 8205; i++) issue(1, 1, 32'h0000_7000, 0, "R7 R8 R9 fail run");
        issue(1, 1, 32'h0000_7000, 1, "R5 bypass keeps count");
        issue(1, 1, 32'h0000_7000, 0, "R9 saturated");
        // R3: pass resets count, next warn after 10 more
        issue(0, 1, 32'h0000_7000, 0, "R3 link");
        issue(1, 1, 32'h0000_7004, 0, "R3 pass");
        for (int i = 0; i < 10; i++) issue(1, 1, 32'h0000_7000, 0, "R3 R7 count restarted");
        idle(2);
        // R10: reset clears sticky flag
        @(negedge clk);
        rst = 1'b1;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        chk("R10", "fatal after reset", 32'(fatal), 32'd0);
        chk("R10", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        issue(1, 1, 32'h0000_7000, 0, "R10 count cleared");
        idle(3);
        chk("scoreboard", "queue drained", 32'(q.size()), 32'd0);
        finish_run();
    end

endmodule